// File: doc/BRIEF.md
# Dual-Clock FIFO with Level Flags

This block carries 8-bit words from a write clock domain into an unrelated read clock domain through an 8-entry buffer. A producer presents a word together with a write strobe on its own clock. A consumer raises a read strobe on a different clock and receives the oldest stored word on the next read-clock edge. A single active-high reset clears both sides. It must stay high for several cycles of both clocks.

Each side keeps a binary pointer with one wrap bit beyond the address. A Gray-coded copy of each pointer is carried into the opposite domain through a two-stage flip-flop synchronizer. The write side uses its own pointer and the synchronized read pointer to compute full, almost-full and half-full. The read side computes empty and almost-empty from its own pointer and the synchronized write pointer. Each flag therefore reacts at once to its own side's traffic and a few cycles late to the other side's traffic. The late reaction always errs toward caution.

Top module: `xdom_fifo`

## Requirements
- R1: While reset is high, and after it is released with no traffic, empty reads 1, full, almost_full, almost_empty and half read 0, and rd_data reads zero, even if words were stored before the reset.
- R2: Words leave in the order they were written. rd_data takes the oldest word on the rd_clk edge where rd_en is high and empty is low, and holds its value otherwise. This also holds when writes and reads run at the same time.
- R3: After 8 accepted writes with no reads, full reads 1. A write while full is dropped: it neither overwrites stored data nor moves the write pointer.
- R4: A read while empty is dropped: empty stays 1, rd_data keeps its value and the read pointer does not move.
- R5: almost_full reads 1 exactly when the write-side occupancy (write pointer minus synchronized read pointer) is 6 or more. full implies almost_full and half.
- R6: almost_empty reads 1 exactly when the read-side occupancy (synchronized write pointer minus read pointer) is 1.
- R7: half reads 1 exactly when the write-side occupancy is 4 or more.
- R8: Pointers wrap modulo 16 with addresses modulo 8, so traffic that crosses the end of the storage returns every word intact and in order.
- R9: Each Gray-coded pointer changes in at most one bit per cycle of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, independent of wr_clk |
| rst | input | 1 | Shared synchronous active-high reset for both domains |
| wr_en | input | 1 | Write strobe, sampled on wr_clk |
| rd_en | input | 1 | Read strobe, sampled on rd_clk |
| wr_data | input | 8 | Word to store |
| rd_data | output | 8 | Last word read; zero after reset |
| full | output | 1 | No free entry (write domain) |
| empty | output | 1 | No stored entry (read domain) |
| almost_full | output | 1 | Write-side occupancy at least 6 |
| almost_empty | output | 1 | Read-side occupancy exactly 1 |
| half | output | 1 | Write-side occupancy at least 4 |

## Verification
A write and a read can both be accepted in the same period. The two domains then move their pointers together, and each flag sees the other pointer only through the synchronizer. The bench provokes this by preloading two words. It then holds wr_en high for six consecutive write cycles while a reader on the 2.5x faster read clock pulls a word whenever empty is low. Every word that arrives must match the written sequence, and the buffer must finish empty with no word lost or repeated.

// File: rtl/xf_pkg.sv
package xf_pkg;

    localparam int XF_DATA_W = 8;
    localparam int XF_ADDR_W = 3;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half;
    } wr_status_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_status_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xf_sync.sv
module xf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/xf_mem.sv
module xf_mem #(
    parameter int DW = 8,
    parameter int AW = 3,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xf_wside.sv
module xf_wside
    import xf_pkg::*;
#(
    parameter int AW        = 3,
    parameter int AFULL_LVL = 6,
    parameter int HALF_LVL  = 4,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_go,
    output wr_status_t    st
);
    logic [PW-1:0] wbin, wbin_n, rbin_s, occ;

    assign wr_go  = wr_en && !st.full;
    assign wbin_n = wbin + PW'(wr_go);
    assign waddr  = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_n;
            wgray <= PW'(bin_to_gray(32'(wbin_n)));
        end
    end

    assign rbin_s = PW'(gray_to_bin(32'(rgray_s)));
    assign occ    = wbin - rbin_s;

    always_comb begin
        st.full        = (wgray == {~rgray_s[PW-1 -: 2], rgray_s[PW-3:0]});
        st.almost_full = (occ >= PW'(AFULL_LVL));
        st.half        = (occ >= PW'(HALF_LVL));
    end

    assert_wr_hold_full_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st.full) |=> $stable(wbin));

    assert_wgray_step_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_full_levels_R5: assert property (@(posedge clk) disable iff (rst)
        st.full |-> (st.almost_full && st.half));
endmodule

// File: rtl/xf_rside.sv
module xf_rside
    import xf_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 3,
    parameter int AEMPTY_LVL = 1,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data,
    output rd_status_t    st
);
    logic [PW-1:0] rbin, rbin_n, wbin_s, occ;
    logic          rd_go;

    assign rd_go  = rd_en && !st.empty;
    assign rbin_n = rbin + PW'(rd_go);
    assign raddr  = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else begin
            rbin  <= rbin_n;
            rgray <= PW'(bin_to_gray(32'(rbin_n)));
            if (rd_go) rd_data <= mem_q;
        end
    end

    assign wbin_s = PW'(gray_to_bin(32'(wgray_s)));
    assign occ    = wbin_s - rbin;

    always_comb begin
        st.empty        = (rgray == wgray_s);
        st.almost_empty = !st.empty && (occ <= PW'(AEMPTY_LVL));
    end

    assert_rd_hold_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && st.empty) |=> ($stable(rbin) && $stable(rd_data)));

    assert_rd_step_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !st.empty) |=> (rbin == PW'($past(rbin) + 1'b1)));

    assert_rgray_step_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);

    assert_rd_data_reset_R1: assert property (@(posedge clk)
        rst |=> (rd_data == '0));
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
    import xf_pkg::*;
#(
    parameter int DATA_W      = XF_DATA_W,
    parameter int ADDR_W      = XF_ADDR_W,
    parameter int AFULL_LVL   = 6,
    parameter int AEMPTY_LVL  = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              half
);
    localparam int PW       = ADDR_W + 1;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int HALF_LVL = DEPTH / 2;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              wr_go;
    logic [DATA_W-1:0] mem_q;
    wr_status_t        wst;
    rd_status_t        rst_flags;

    xf_wside #(.AW(ADDR_W), .AFULL_LVL(AFULL_LVL), .HALF_LVL(HALF_LVL)) u_wside (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .rgray_s(rgray_s),
        .wgray(wgray), .waddr(waddr), .wr_go(wr_go), .st(wst)
    );

    xf_rside #(.DW(DATA_W), .AW(ADDR_W), .AEMPTY_LVL(AEMPTY_LVL)) u_rside (
        .clk(rd_clk), .rst(rst), .rd_en(rd_en), .wgray_s(wgray_s), .mem_q(mem_q),
        .rgray(rgray), .raddr(raddr), .rd_data(rd_data), .st(rst_flags)
    );

    xf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    xf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    xf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    assign full         = wst.full;
    assign almost_full  = wst.almost_full;
    assign half         = wst.half;
    assign empty        = rst_flags.empty;
    assign almost_empty = rst_flags.almost_empty;
endmodule

// File: tb/xdom_fifo_bench.sv
`timescale 1ns/1ps
module xdom_fifo_bench;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       full, empty, almost_full, almost_empty, half;

    int n_chk = 0;
    int n_err = 0;

    always #10 wclk = ~wclk;   // 50 MHz write clock
    always #4  rclk = ~rclk;   // faster read clock

    xdom_fifo u_xdom_fifo (
        .wr_clk(wclk), .rd_clk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty), .half(half)
    );

    // {is_read, data, full, almost_full, half, almost_empty, empty}
    localparam logic [13:0] VEC [16] = '{
        {1'b0, 8'h11, 5'b00010}, {1'b0, 8'h22, 5'b00000},
        {1'b0, 8'h33, 5'b00000}, {1'b0, 8'h44, 5'b00100},
        {1'b0, 8'h55, 5'b00100}, {1'b0, 8'h66, 5'b01100},
        {1'b0, 8'h77, 5'b01100}, {1'b0, 8'h88, 5'b11100},
        {1'b1, 8'h11, 5'b01100}, {1'b1, 8'h22, 5'b01100},
        {1'b1, 8'h33, 5'b00100}, {1'b1, 8'h44, 5'b00100},
        {1'b1, 8'h55, 5'b00000}, {1'b1, 8'h66, 5'b00000},
        {1'b1, 8'h77, 5'b00010}, {1'b1, 8'h88, 5'b00001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic settle();
        repeat (4) @(negedge wclk);
    endtask

    task automatic do_reset();
        @(negedge wclk);
        rst = 1'b1;
        repeat (3) @(negedge wclk);
        rst = 1'b0;
        settle();
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge wclk);
        wr_en   = 1'b0;
    endtask

    task automatic rd();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 empty"}, 32'(empty), 32'd1);
        chk({tag, " R1 full"}, 32'(full), 32'd0);
        chk({tag, " R1 almost_full"}, 32'(almost_full), 32'd0);
        chk({tag, " R1 almost_empty"}, 32'(almost_empty), 32'd0);
        chk({tag, " R1 half"}, 32'(half), 32'd0);
        chk({tag, " R1 rd_data"}, 32'(rd_data), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge wclk);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        do_reset();
        chk_idle("reset");

        // R4: read on empty is dropped
        rd();
        settle();
        chk("R4 empty after read on empty", 32'(empty), 32'd1);
        chk("R4 rd_data held", 32'(rd_data), 32'd0);

        // table walk: fill then drain, flags after each step
        for (int i = 0; i < 16; i++) begin
            if (VEC[i][13]) rd();
            else            wr(VEC[i][12:5]);
            settle();
            chk("R3 full level", 32'(full), 32'(VEC[i][4]));
            chk("R5 almost_full level", 32'(almost_full), 32'(VEC[i][3]));
            chk("R7 half level", 32'(half), 32'(VEC[i][2]));
            chk("R6 almost_empty level", 32'(almost_empty), 32'(VEC[i][1]));
            chk("R4 empty level", 32'(empty), 32'(VEC[i][0]));
            if (VEC[i][13]) chk("R2 read order", 32'(rd_data), 32'(VEC[i][12:5]));
        end

        // R4: read on empty keeps last word
        rd();
        settle();
        chk("R4 rd_data held after drain", 32'(rd_data), 32'h88);
        chk("R4 empty held", 32'(empty), 32'd1);

        // R3: write while full is dropped
        for (int i = 0; i < 8; i++) wr(8'hA0 + 8'(i));
        settle();
        chk("R3 full after 8 writes", 32'(full), 32'd1);
        wr(8'hEE);
        settle();
        chk("R3 full after extra write", 32'(full), 32'd1);
        for (int i = 0; i < 8; i++) begin
            rd();
            chk("R3 contents intact", 32'(rd_data), 32'(8'hA0 + 8'(i)));
        end
        settle();
        chk("R3 empty after drain (no extra word)", 32'(empty), 32'd1);

        // R8: traffic crossing the end of storage
        for (int i = 0; i < 3; i++) wr(8'hB0 + 8'(i));
        for (int i = 0; i < 3; i++) begin
            rd();
            chk("R8 offset words", 32'(rd_data), 32'(8'hB0 + 8'(i)));
        end
        for (int i = 0; i < 8; i++) wr(8'hC0 + 8'(i));
        settle();
        chk("R8 full after wrap fill", 32'(full), 32'd1);
        for (int i = 0; i < 8; i++) begin
            rd();
            chk("R8 wrapped words", 32'(rd_data), 32'(8'hC0 + 8'(i)));
        end
        settle();
        chk("R8 empty after wrap drain", 32'(empty), 32'd1);

        // R2: concurrent write burst and reads
        wr(8'hD0);
        wr(8'hD1);
        fork
            begin
                for (int i = 2; i < 8; i++) begin
                    @(negedge wclk);
                    wr_en   = 1'b1;
                    wr_data = 8'hD0 + 8'(i);
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 8; i++) begin
                    @(negedge rclk);
                    while (empty) @(negedge rclk);
                    rd_en = 1'b1;
                    @(negedge rclk);
                    rd_en = 1'b0;
                    chk("R2 concurrent order", 32'(rd_data), 32'(8'hD0 + 8'(i)));
                end
            end
        join
        settle();
        chk("R2 empty after concurrent run", 32'(empty), 32'd1);
        chk("R2 full clear after concurrent run", 32'(full), 32'd0);

        // R1: reset clears stored words
        wr(8'h5A);
        wr(8'h5B);
        wr(8'h5C);
        settle();
        chk("R1 not empty before reset", 32'(empty), 32'd0);
        do_reset();
        chk_idle("reset with data");

        report();
        $finish;
    end
endmodule